// File: doc/BRIEF.md
# Operating Mode Clock Gating Controller

This block is the system-integration controller that follows the chip's operating mode and turns that mode into registered clock enables for each clock domain and into the reset lines for the core and the peripherals. The domains are the processor core, the memories, the general peripherals, the watchdog, the CAN-style wake source and the PLL. It also drives a PWM output-disable line and a watchdog freeze line. It leaves power-on through a total reset. It then holds only the core in reset until the flash interface reports that its registers are loaded. After that it runs the chip. It honours debug requests, wait and stop instructions, software and watchdog reset requests, and wake interrupts.

There are three low-power or halted modes: debug, wait and stop. Each one gates a different set of domains. Option inputs decide for each mode whether the watchdog stops, whether PWM outputs are forced off and whether the CAN domain keeps its clock in stop. The PLL is never powered down automatically. It goes down only when an explicit request is held in the same cycle in which the stop instruction is taken.

Top module: `opm_clock_gate`

## Requirements
- R1: While porN is low (asynchronous), the block is in total reset. In total reset, coreRstN and periphRstN are 0, and coreClkEn, memClkEn, periphClkEn, wdClkEn, canClkEn and pllEn are 1. pwmOutDisable and wdFreeze are 0. coreRstN is never 1 while periphRstN is 0.
- R2: A high swResetReq or wdResetReq at a rising edge enters total reset from any mode. Total reset lasts while a request is held. At the first edge with no request, the block moves to core-only reset.
- R3: Core-only reset drives coreRstN=0 and periphRstN=1 with every clock enabled. Debug, wait and stop requests are ignored in this mode. It lasts until an edge at which flashLoadDone is high, and the block then enters run mode.
- R4: In run mode every clock enable is 1, both resets are 1, and pwmOutDisable and wdFreeze are 0.
- R5: A debugReq is taken only in run mode, and it takes priority over stopReq and waitReq. Debug mode lasts while debugReq stays high and returns to run mode when it is low. In debug, wdClkEn=0, wdFreeze=1 and pwmOutDisable=optPwmOffDebug, and all other clocks stay on.
- R6: waitReq in run mode enters wait mode, when neither debugReq nor stopReq is present. In wait, coreClkEn=memClkEn=0 and periphClkEn=canClkEn=pllEn=1. wdClkEn=!optWdOffWait, wdFreeze=optWdOffWait and pwmOutDisable=optPwmOffWait.
- R7: In wait mode, irqAny or irqUngated high at an edge returns the block to run mode at that edge, with core and memory clocks enabled again.
- R8: stopReq in run mode enters stop mode when debugReq is absent, and it takes priority over waitReq. In stop, coreClkEn=memClkEn=periphClkEn=0 and pwmOutDisable=0. wdClkEn=!optWdOffStop, wdFreeze=optWdOffStop and canClkEn=!optCanOffStop.
- R9: Stop mode is left for run mode only by irqUngated, or by canWake while optCanOffStop=0. irqAny alone does not end stop mode, and neither does canWake while the CAN domain is stopped.
- R10: pllEn is 0 only in a stop mode that was entered with pllOffReq high at the same edge as stopReq. Otherwise pllEn stays 1 in stop, and it returns to 1 when stop ends.
- R11: Every output is a register on clk. The outputs for a new mode appear at the same rising edge at which the inputs causing that mode are sampled, and option changes take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| swResetReq | input | 1 | Software reset request |
| wdResetReq | input | 1 | Watchdog reset request |
| flashLoadDone | input | 1 | Flash interface has finished loading its registers |
| debugReq | input | 1 | Debug halt request (level) |
| waitReq | input | 1 | Wait instruction strobe |
| stopReq | input | 1 | Stop instruction strobe |
| pllOffReq | input | 1 | Explicit PLL power-down request for the next stop |
| optWdOffWait | input | 1 | Stop watchdog in wait |
| optPwmOffWait | input | 1 | Force PWM outputs off in wait |
| optPwmOffDebug | input | 1 | Force PWM outputs off in debug |
| optWdOffStop | input | 1 | Stop watchdog in stop |
| optCanOffStop | input | 1 | Stop CAN domain clock in stop |
| irqAny | input | 1 | Any enabled (gated) interrupt |
| irqUngated | input | 1 | Non-gated interrupt, able to wake from stop |
| canWake | input | 1 | CAN wake event |
| coreRstN | output | 1 | Core reset, active low |
| periphRstN | output | 1 | Peripheral reset, active low |
| coreClkEn | output | 1 | Core clock enable |
| memClkEn | output | 1 | Memory clock enable |
| periphClkEn | output | 1 | General peripheral clock enable |
| wdClkEn | output | 1 | Watchdog clock enable |
| canClkEn | output | 1 | CAN domain clock enable |
| pllEn | output | 1 | PLL power enable |
| pwmOutDisable | output | 1 | Forces PWM outputs off |
| wdFreeze | output | 1 | Freezes the watchdog |

## Verification
Every synchronous result is due at the rising edge that samples its cause. The bench therefore drives inputs just after a falling edge. At that moment it advances its own mode model with the same inputs, and it compares all ten outputs at the following falling edge. porN is the only asynchronous input, and its effect is checked within the same low phase without waiting for a clock. The directed part covers wake cases that must not end a mode, priority between simultaneous requests and the two PLL cases. The random part mixes all inputs under a fixed seed.

// File: rtl/opm_pkg.sv
package opm_pkg;

  typedef enum logic [2:0] {
    M_TOTAL = 3'd0,
    M_CORE  = 3'd1,
    M_RUN   = 3'd2,
    M_DEBUG = 3'd3,
    M_WAIT  = 3'd4,
    M_STOP  = 3'd5
  } opMode_e;

  // One-hot strobes for the mode about to be entered; none set means run.
  typedef struct packed {
    logic total;
    logic coreOnly;
    logic debug;
    logic waitM;
    logic stopM;
    logic pllDown;
  } modeStrobe_t;

  localparam int NUM_MODE_STROBES = 5;

endpackage

// File: rtl/opm_mode_fsm.sv
module opm_mode_fsm
  import opm_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        swResetReq,
  input  logic        wdResetReq,
  input  logic        flashLoadDone,
  input  logic        debugReq,
  input  logic        waitReq,
  input  logic        stopReq,
  input  logic        pllOffReq,
  input  logic        optCanOffStop,
  input  logic        irqAny,
  input  logic        irqUngated,
  input  logic        canWake,
  output modeStrobe_t strobe
);

  opMode_e curMode, nextMode;
  logic    pllArmed, nextArmed;
  logic    anyResetReq;
  logic    stopWake;

  assign anyResetReq = swResetReq | wdResetReq;
  assign stopWake    = irqUngated | (canWake & ~optCanOffStop);

  always_comb begin
    nextMode = curMode;
    if (anyResetReq) begin
      nextMode = M_TOTAL;
    end else begin
      unique case (curMode)
        M_TOTAL: nextMode = M_CORE;
        M_CORE:  if (flashLoadDone) nextMode = M_RUN;
        M_RUN: begin
          if (debugReq)      nextMode = M_DEBUG;
          else if (stopReq)  nextMode = M_STOP;
          else if (waitReq)  nextMode = M_WAIT;
        end
        M_DEBUG: if (!debugReq) nextMode = M_RUN;
        M_WAIT:  if (irqAny || irqUngated) nextMode = M_RUN;
        M_STOP:  if (stopWake) nextMode = M_RUN;
        default: nextMode = M_TOTAL;
      endcase
    end
  end

  always_comb begin
    nextArmed = 1'b0;
    if (nextMode == M_STOP) begin
      nextArmed = (curMode == M_RUN) ? pllOffReq : pllArmed;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      curMode  <= M_TOTAL;
      pllArmed <= 1'b0;
    end else begin
      curMode  <= nextMode;
      pllArmed <= nextArmed;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.total    = (nextMode == M_TOTAL);
    strobe.coreOnly = (nextMode == M_CORE);
    strobe.debug    = (nextMode == M_DEBUG);
    strobe.waitM    = (nextMode == M_WAIT);
    strobe.stopM    = (nextMode == M_STOP);
    strobe.pllDown  = nextArmed;
  end

  AST_RESET_ANY: assert property (@(posedge clk) disable iff (!porN)
    (swResetReq || wdResetReq) |=> (curMode == M_TOTAL)); // R2

  AST_FLASH_HOLD: assert property (@(posedge clk) disable iff (!porN)
    (curMode == M_CORE && !flashLoadDone && !swResetReq && !wdResetReq)
      |=> (curMode == M_CORE)); // R3

  AST_DEBUG_FROM_RUN: assert property (@(posedge clk) disable iff (!porN)
    (curMode == M_DEBUG) |-> ($past(curMode) == M_RUN || $past(curMode) == M_DEBUG)); // R5

  AST_WAIT_WAKE: assert property (@(posedge clk) disable iff (!porN)
    (curMode == M_WAIT && (irqAny || irqUngated))
      |=> (curMode == M_RUN || curMode == M_TOTAL)); // R7

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!porN)
    (curMode == M_STOP && !canWake && !irqUngated && !swResetReq && !wdResetReq)
      |=> (curMode == M_STOP)); // R9

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!porN)
    $onehot0({strobe.total, strobe.coreOnly, strobe.debug, strobe.waitM, strobe.stopM})); // R11

endmodule

// File: rtl/opm_gate_regs.sv
module opm_gate_regs
  import opm_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  modeStrobe_t strobe,
  input  logic        optWdOffWait,
  input  logic        optPwmOffWait,
  input  logic        optPwmOffDebug,
  input  logic        optWdOffStop,
  input  logic        optCanOffStop,
  output logic        coreRstN,
  output logic        periphRstN,
  output logic        coreClkEn,
  output logic        memClkEn,
  output logic        periphClkEn,
  output logic        wdClkEn,
  output logic        canClkEn,
  output logic        pllEn,
  output logic        pwmOutDisable,
  output logic        wdFreeze
);

  typedef struct packed {
    logic coreRstN;
    logic periphRstN;
    logic coreClkEn;
    logic memClkEn;
    logic periphClkEn;
    logic wdClkEn;
    logic canClkEn;
    logic pllEn;
    logic pwmOutDisable;
    logic wdFreeze;
  } gateOut_t;

  localparam gateOut_t RUN_VALUE = '{
    coreRstN: 1'b1, periphRstN: 1'b1, coreClkEn: 1'b1, memClkEn: 1'b1,
    periphClkEn: 1'b1, wdClkEn: 1'b1, canClkEn: 1'b1, pllEn: 1'b1,
    pwmOutDisable: 1'b0, wdFreeze: 1'b0};

  localparam gateOut_t RESET_VALUE = '{
    coreRstN: 1'b0, periphRstN: 1'b0, coreClkEn: 1'b1, memClkEn: 1'b1,
    periphClkEn: 1'b1, wdClkEn: 1'b1, canClkEn: 1'b1, pllEn: 1'b1,
    pwmOutDisable: 1'b0, wdFreeze: 1'b0};

  gateOut_t nextOut, outReg;

  always_comb begin
    nextOut = RUN_VALUE;
    if (strobe.total) begin
      nextOut = RESET_VALUE;
    end else if (strobe.coreOnly) begin
      nextOut.coreRstN = 1'b0;
    end else if (strobe.debug) begin
      nextOut.wdClkEn       = 1'b0;
      nextOut.wdFreeze      = 1'b1;
      nextOut.pwmOutDisable = optPwmOffDebug;
    end else if (strobe.waitM) begin
      nextOut.coreClkEn     = 1'b0;
      nextOut.memClkEn      = 1'b0;
      nextOut.wdClkEn       = ~optWdOffWait;
      nextOut.wdFreeze      = optWdOffWait;
      nextOut.pwmOutDisable = optPwmOffWait;
    end else if (strobe.stopM) begin
      nextOut.coreClkEn   = 1'b0;
      nextOut.memClkEn    = 1'b0;
      nextOut.periphClkEn = 1'b0;
      nextOut.wdClkEn     = ~optWdOffStop;
      nextOut.wdFreeze    = optWdOffStop;
      nextOut.canClkEn    = ~optCanOffStop;
      nextOut.pllEn       = ~strobe.pllDown;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) outReg <= RESET_VALUE;
    else       outReg <= nextOut;
  end

  assign coreRstN      = outReg.coreRstN;
  assign periphRstN    = outReg.periphRstN;
  assign coreClkEn     = outReg.coreClkEn;
  assign memClkEn      = outReg.memClkEn;
  assign periphClkEn   = outReg.periphClkEn;
  assign wdClkEn       = outReg.wdClkEn;
  assign canClkEn      = outReg.canClkEn;
  assign pllEn         = outReg.pllEn;
  assign pwmOutDisable = outReg.pwmOutDisable;
  assign wdFreeze      = outReg.wdFreeze;

  AST_PERIPH_FIRST: assert property (@(posedge clk) disable iff (!porN)
    coreRstN |-> periphRstN); // R1

  AST_WD_EXCL: assert property (@(posedge clk) disable iff (!porN)
    wdFreeze |-> !wdClkEn); // R5

  AST_CLK_NEST: assert property (@(posedge clk) disable iff (!porN)
    !periphClkEn |-> (!coreClkEn && !memClkEn)); // R8

  AST_PLL_STOP_ONLY: assert property (@(posedge clk) disable iff (!porN)
    !pllEn |-> !periphClkEn); // R10

endmodule

// File: rtl/opm_clock_gate.sv
module opm_clock_gate
  import opm_pkg::*;
(
  input  logic clk,
  input  logic porN,
  input  logic swResetReq,
  input  logic wdResetReq,
  input  logic flashLoadDone,
  input  logic debugReq,
  input  logic waitReq,
  input  logic stopReq,
  input  logic pllOffReq,
  input  logic optWdOffWait,
  input  logic optPwmOffWait,
  input  logic optPwmOffDebug,
  input  logic optWdOffStop,
  input  logic optCanOffStop,
  input  logic irqAny,
  input  logic irqUngated,
  input  logic canWake,
  output logic coreRstN,
  output logic periphRstN,
  output logic coreClkEn,
  output logic memClkEn,
  output logic periphClkEn,
  output logic wdClkEn,
  output logic canClkEn,
  output logic pllEn,
  output logic pwmOutDisable,
  output logic wdFreeze
);

  modeStrobe_t strobe;

  opm_mode_fsm u_fsm (
    .clk           (clk),
    .porN          (porN),
    .swResetReq    (swResetReq),
    .wdResetReq    (wdResetReq),
    .flashLoadDone (flashLoadDone),
    .debugReq      (debugReq),
    .waitReq       (waitReq),
    .stopReq       (stopReq),
    .pllOffReq     (pllOffReq),
    .optCanOffStop (optCanOffStop),
    .irqAny        (irqAny),
    .irqUngated    (irqUngated),
    .canWake       (canWake),
    .strobe        (strobe)
  );

  opm_gate_regs u_gate (
    .clk            (clk),
    .porN           (porN),
    .strobe         (strobe),
    .optWdOffWait   (optWdOffWait),
    .optPwmOffWait  (optPwmOffWait),
    .optPwmOffDebug (optPwmOffDebug),
    .optWdOffStop   (optWdOffStop),
    .optCanOffStop  (optCanOffStop),
    .coreRstN       (coreRstN),
    .periphRstN     (periphRstN),
    .coreClkEn      (coreClkEn),
    .memClkEn       (memClkEn),
    .periphClkEn    (periphClkEn),
    .wdClkEn        (wdClkEn),
    .canClkEn       (canClkEn),
    .pllEn          (pllEn),
    .pwmOutDisable  (pwmOutDisable),
    .wdFreeze       (wdFreeze)
  );

endmodule

// File: tb/opm_clock_gate_test.sv
`timescale 1ns/1ps
module opm_clock_gate_test;

  localparam int TOT = 0, CORE = 1, RUN = 2, DBG = 3, WAITM = 4, STOPM = 5;

  logic clk = 1'b0;
  logic porN = 1'b1;
  logic swResetReq = 0, wdResetReq = 0, flashLoadDone = 0, debugReq = 0;
  logic waitReq = 0, stopReq = 0, pllOffReq = 0;
  logic optWdOffWait = 0, optPwmOffWait = 0, optPwmOffDebug = 0;
  logic optWdOffStop = 0, optCanOffStop = 0;
  logic irqAny = 0, irqUngated = 0, canWake = 0;
  logic coreRstN, periphRstN, coreClkEn, memClkEn, periphClkEn;
  logic wdClkEn, canClkEn, pllEn, pwmOutDisable, wdFreeze;

  int vectors = 0;
  int miscompares = 0;
  int mMode = TOT;
  logic mArmed = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  opm_clock_gate uut (.*);

  // Expected outputs {coreRstN,periphRstN,coreClk,memClk,periphClk,wdClk,canClk,pll,pwmOff,wdFreeze}
  function automatic logic [9:0] expOut(int m, logic armed);
    logic [9:0] v;
    case (m)
      TOT:   v = 10'b00_11111_1_00;                              // R1 R2
      CORE:  v = 10'b01_11111_1_00;                              // R3
      DBG:   v = {2'b11, 3'b111, 1'b0, 1'b1, 1'b1, optPwmOffDebug, 1'b1}; // R5
      WAITM: v = {2'b11, 3'b001, ~optWdOffWait, 1'b1, 1'b1, optPwmOffWait, optWdOffWait}; // R6
      STOPM: v = {2'b11, 3'b000, ~optWdOffStop, ~optCanOffStop, ~armed, 1'b0, optWdOffStop}; // R8 R10
      default: v = 10'b11_11111_1_00;                            // R4
    endcase
    return v;
  endfunction

  function automatic int nextModeOf(int m);
    if (swResetReq || wdResetReq) return TOT;
    case (m)
      TOT:   return CORE;
      CORE:  return flashLoadDone ? RUN : CORE;
      RUN:   return debugReq ? DBG : stopReq ? STOPM : waitReq ? WAITM : RUN;
      DBG:   return debugReq ? DBG : RUN;
      WAITM: return (irqAny || irqUngated) ? RUN : WAITM;
      default: return (irqUngated || (canWake && !optCanOffStop)) ? RUN : STOPM;
    endcase
  endfunction

  function automatic string modeTag(int m);
    case (m)
      TOT: return "R2"; CORE: return "R3"; RUN: return "R4";
      DBG: return "R5"; WAITM: return "R6"; default: return "R8";
    endcase
  endfunction

  task automatic compare(string tag);
    logic [9:0] act, exp;
    act = {coreRstN, periphRstN, coreClkEn, memClkEn, periphClkEn,
           wdClkEn, canClkEn, pllEn, pwmOutDisable, wdFreeze};
    exp = expOut(mMode, mArmed);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s mode=%0d actual=%b expected=%b", tag, mMode, act, exp);
    end
  endtask

  // Inputs are already driven after a falling edge; the model takes the
  // rising edge and outputs are compared at the next falling edge (R11).
  task automatic cycle(string tag);
    int nm;
    logic na;
    if (!porN) begin
      nm = TOT; na = 1'b0;
    end else begin
      nm = nextModeOf(mMode);
      na = (nm == STOPM) ? ((mMode == RUN) ? pllOffReq : mArmed) : 1'b0;
    end
    @(negedge clk);
    mMode = nm; mArmed = na;
    compare(tag == "" ? modeTag(mMode) : tag);
  endtask

  task automatic clearIn();
    swResetReq = 0; wdResetReq = 0; debugReq = 0; waitReq = 0; stopReq = 0;
    pllOffReq = 0; irqAny = 0; irqUngated = 0; canWake = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    #1 porN = 1'b0;
    #3 compare("R1");                          // async reset, before any edge
    @(negedge clk); compare("R1");
    porN = 1'b1;
    cycle("R3");                               // total -> core-only
    debugReq = 1; waitReq = 1; stopReq = 1;
    cycle("R3"); cycle("R3");                  // requests ignored, flash not done
    clearIn(); flashLoadDone = 1;
    cycle("R3");                               // to run
    cycle("R4");
    // wait with watchdog stopped and PWM off
    optWdOffWait = 1; optPwmOffWait = 1; waitReq = 1;
    cycle("R6"); clearIn();
    canWake = 1; cycle("R7"); clearIn();       // canWake does not end wait
    irqAny = 1; cycle("R7"); clearIn();        // wake to run
    // stop has priority over wait, PLL armed
    stopReq = 1; waitReq = 1; pllOffReq = 1; optWdOffStop = 1; optCanOffStop = 1;
    cycle("R10"); clearIn();
    irqAny = 1; cycle("R9"); clearIn();        // gated irq ignored in stop
    canWake = 1; cycle("R9"); clearIn();       // CAN stopped: no wake
    irqUngated = 1; cycle("R9"); clearIn();    // wake, pll back on
    // stop without PLL request
    optCanOffStop = 0; optWdOffStop = 0; stopReq = 1;
    cycle("R10"); clearIn();
    canWake = 1; cycle("R9"); clearIn();
    // debug beats stop and wait
    optPwmOffDebug = 1; debugReq = 1; stopReq = 1; waitReq = 1;
    cycle("R5"); stopReq = 0; waitReq = 0;
    cycle("R5"); debugReq = 0;
    cycle("R5");
    // software and watchdog reset
    swResetReq = 1; cycle("R2"); cycle("R2"); clearIn();
    flashLoadDone = 0; cycle("R2"); cycle("R3");
    flashLoadDone = 1; cycle("R3");
    waitReq = 1; cycle("R6"); clearIn();
    wdResetReq = 1; cycle("R2"); clearIn();
    cycle("R3");

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      swResetReq     = ($urandom % 80) == 0;
      wdResetReq     = ($urandom % 120) == 0;
      flashLoadDone  = ($urandom % 3) == 0;
      debugReq       = ($urandom % 6) == 0;
      waitReq        = ($urandom % 6) == 0;
      stopReq        = ($urandom % 6) == 0;
      pllOffReq      = $urandom % 2;
      irqAny         = ($urandom % 5) == 0;
      irqUngated     = ($urandom % 9) == 0;
      canWake        = ($urandom % 5) == 0;
      optWdOffWait   = $urandom % 2;
      optPwmOffWait  = $urandom % 2;
      optPwmOffDebug = $urandom % 2;
      optWdOffStop   = $urandom % 2;
      optCanOffStop  = $urandom % 2;
      porN           = ($urandom % 300) != 0;  // R1 occasional power-on reset
      cycle("");
      porN = 1'b1;
    end
    finishRun();
  end

endmodule